// File: doc/BRIEF.md
# Compressed-Memory Page Location Cache

This block is a small fully associative cache that sits beside the L2 cache. It turns the frame number of a physical address into the frame where that page is actually stored in a main memory that holds some pages in compressed form. The page-table walker loads it: each time the walker fetches a page-table entry, it also delivers a location record for the page that the entry maps. The record holds a compression state code and, for a compressed page, a storage frame.

A regular data access presents its physical address and receives a storage address one cycle later. For an uncompressed page that address equals the physical address. For a compressed page it is the stored frame with the original page offset appended. Reads issued by the walker itself carry a flag and are never translated, because page-table pages are always kept uncompressed. A lookup that misses holds the access port until the record for that frame arrives. An invalidate input drops a record when a page changes its compression state.

Top module: `cmp_xlat_cache`

## Requirements
- R1: After reset every entry is empty, `reqReady` is 1, and `missPending` and `rspValid` are 0. The first regular lookup of any frame therefore misses.
- R2: A request with `reqWalk`=1 is accepted in any entry state. It gives `rspValid`=1 in the next cycle with `rspAddr` equal to `reqAddr` and `rspState`=0, and it does not count as a use for replacement.
- R3: A regular request that hits an entry whose state code is 0 (uncompressed) gives `rspValid`=1 in the next cycle, with `rspAddr` equal to `reqAddr` and `rspState`=0.
- R4: A regular request that hits an entry whose state code is nonzero (compressed, codes 1..3) gives, in the next cycle, `rspAddr` = {stored frame, `reqAddr[11:0]`} and `rspState` = the stored code.
- R5: A regular request that misses raises `missPending` and drops `reqReady` from the next cycle on, with no response. Fills for other frames are installed but do not release the wait. The fill whose frame matches ends the wait, and the response is built from that fill's data in the next cycle.
- R6: A fill whose frame is already held overwrites that entry in place. Later lookups return the new data, and no second entry is made.
- R7: When every entry is valid, a fill of an absent frame replaces the entry least recently used. Regular hits and fills count as uses; walker reads do not. While an empty entry exists, that entry is used instead of evicting.
- R8: An invalidate removes the entry for the given frame, so the next regular lookup of it misses. A regular lookup in the same cycle as an invalidate of its frame also misses.
- R9: A regular lookup in the same cycle as a fill of the same frame hits at once on the fill data, without a miss.
- R10: A fill and an invalidate of the same frame in the same cycle leave the entry valid with the filled data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request present |
| reqWalk | input | 1 | Request is a page-table-walk read (bypass) |
| reqAddr | input | 48 | Physical address: frame [47:12], offset [11:0] |
| reqReady | output | 1 | Request accepted this cycle (low while a miss waits) |
| rspValid | output | 1 | Storage address valid |
| rspAddr | output | 48 | Storage address: frame [47:12], offset [11:0] |
| rspState | output | 2 | Compression state code of the page (0 = uncompressed) |
| missPending | output | 1 | A regular lookup missed and waits for its fill |
| fillValid | input | 1 | Location record from the walker |
| fillPpn | input | 36 | Physical frame the record belongs to |
| fillState | input | 2 | Compression state code of the record |
| fillLoc | input | 36 | Storage frame, meaningful only when the state code is nonzero |
| invValid | input | 1 | Drop the record of a frame |
| invPpn | input | 36 | Frame whose record is dropped |

## Verification
A lookup can meet a fill or an invalidate in the same cycle, and these collisions are the points the design must resolve. The bench drives a regular lookup together with a fill of the same frame and expects an immediate hit on the filled data with `missPending` staying low. It drives a lookup together with an invalidate of the same frame and expects a miss and stall, and it drives a fill and an invalidate of one frame together and then expects a later hit on the filled data. A reference list with least-recently-used order, kept in the bench, predicts every hit, miss and eviction, so a wrong victim shows up as an unexpected miss or response.

// File: rtl/cxc_pkg.sv
package cxc_pkg;

  // Source of the registered response
  typedef enum logic [1:0] {
    SRC_BYPASS    = 2'd0,
    SRC_ARRAY     = 2'd1,
    SRC_FILL_NOW  = 2'd2,
    SRC_FILL_WAIT = 2'd3
  } rspSrc_t;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_WAIT = 1'b1
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic    touchHit;
    logic    latchReq;
    logic    loadRsp;
    rspSrc_t rspSrc;
  } ctlStrobe_t;

endpackage

// File: rtl/cxc_datapath.sv
module cxc_datapath
  import cxc_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int FRAME_W = 36,
  parameter int OFF_W   = 12,
  parameter int STATE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [FRAME_W-1:0] reqPpn,
  input  logic [OFF_W-1:0]   reqOff,
  input  logic               fillValid,
  input  logic [FRAME_W-1:0] fillPpn,
  input  logic [STATE_W-1:0] fillState,
  input  logic [FRAME_W-1:0] fillLoc,
  input  logic               invValid,
  input  logic [FRAME_W-1:0] invPpn,
  output logic               lookupHit,
  output logic               invHitsReq,
  output logic               fillHitsReq,
  output logic               fillHitsWait,
  output logic               rspValid,
  output logic [FRAME_W+OFF_W-1:0] rspAddr,
  output logic [STATE_W-1:0] rspState
);

  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int ADDR_W = FRAME_W + OFF_W;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [ENTRIES-1:0][IDX_W-1:0] ageVec_t;

  logic [ENTRIES-1:0] valid;
  logic [FRAME_W-1:0] tagMem [ENTRIES];
  logic [FRAME_W-1:0] locMem [ENTRIES];
  logic [STATE_W-1:0] stMem  [ENTRIES];
  ageVec_t            age;

  logic [FRAME_W-1:0] waitPpn;
  logic [OFF_W-1:0]   waitOff;

  logic [ENTRIES-1:0] lookVec, fillVec, invVec, wrVec, oldestVec;
  idx_t    hitIdx, fillIdx, freeIdx, oldIdx;
  logic    anyFree;
  ageVec_t agesAfterHit, agesNext;

  function automatic idx_t encIdx(input logic [ENTRIES-1:0] v);
    idx_t r;
    r = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (v[i]) r = r | idx_t'(i);
    return r;
  endfunction

  // Mark entry k most recent; younger-than-k entries age by one
  function automatic ageVec_t bumpAges(input ageVec_t a, input idx_t k);
    ageVec_t r;
    for (int i = 0; i < ENTRIES; i++) begin
      if (idx_t'(i) == k)     r[i] = '0;
      else if (a[i] < a[k])   r[i] = a[i] + idx_t'(1);
      else                    r[i] = a[i];
    end
    return r;
  endfunction

  // Per-entry comparators
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lookVec[g]   = valid[g] && (tagMem[g] == reqPpn);
    assign fillVec[g]   = valid[g] && (tagMem[g] == fillPpn);
    assign invVec[g]    = valid[g] && (tagMem[g] == invPpn);
    assign oldestVec[g] = (agesAfterHit[g] == idx_t'(ENTRIES - 1));
    assign wrVec[g]     = fillValid && (fillIdx == idx_t'(g));
  end

  assign lookupHit    = |lookVec;
  assign hitIdx       = encIdx(lookVec);
  assign invHitsReq   = invValid && (invPpn == reqPpn);
  assign fillHitsReq  = (fillPpn == reqPpn);
  assign fillHitsWait = (fillPpn == waitPpn);

  assign agesAfterHit = strobe.touchHit ? bumpAges(age, hitIdx) : age;

  // Victim: lowest empty entry, else the oldest one
  always_comb begin
    freeIdx = '0;
    anyFree = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        freeIdx = idx_t'(i);
        anyFree = 1'b1;
      end
    end
  end

  assign oldIdx  = encIdx(oldestVec);
  assign fillIdx = (|fillVec) ? encIdx(fillVec) : (anyFree ? freeIdx : oldIdx);
  assign agesNext = fillValid ? bumpAges(agesAfterHit, fillIdx) : agesAfterHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid <= '0;
      for (int i = 0; i < ENTRIES; i++) age[i] <= idx_t'(i);
    end else begin
      age <= agesNext;
      for (int i = 0; i < ENTRIES; i++) begin
        if (wrVec[i])                     valid[i] <= 1'b1;
        else if (invValid && invVec[i])   valid[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wrVec[i]) begin
        tagMem[i] <= fillPpn;
        locMem[i] <= fillLoc;
        stMem[i]  <= fillState;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitPpn <= '0;
      waitOff <= '0;
    end else if (strobe.latchReq) begin
      waitPpn <= reqPpn;
      waitOff <= reqOff;
    end
  end

  // Response formation
  logic [FRAME_W-1:0] frameNext;
  logic [OFF_W-1:0]   offNext;
  logic [STATE_W-1:0] stateNext;

  always_comb begin
    frameNext = reqPpn;
    offNext   = reqOff;
    stateNext = '0;
    case (strobe.rspSrc)
      SRC_ARRAY: begin
        stateNext = stMem[hitIdx];
        if (stMem[hitIdx] != '0) frameNext = locMem[hitIdx];
      end
      SRC_FILL_NOW: begin
        stateNext = fillState;
        if (fillState != '0) frameNext = fillLoc;
      end
      SRC_FILL_WAIT: begin
        offNext   = waitOff;
        stateNext = fillState;
        frameNext = (fillState != '0) ? fillLoc : waitPpn;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspAddr  <= '0;
      rspState <= '0;
    end else begin
      rspValid <= strobe.loadRsp;
      if (strobe.loadRsp) begin
        rspAddr  <= ADDR_W'({frameNext, offNext});
        rspState <= stateNext;
      end
    end
  end

  function automatic logic holdsPpn(input logic [FRAME_W-1:0] p);
    logic r;
    r = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (valid[i] && tagMem[i] == p) r = 1'b1;
    return r;
  endfunction

  // R6: a frame never sits in two entries
  p_single_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookVec) && $onehot0(fillVec));

  // R7: ages stay a permutation, exactly one oldest entry
  p_one_oldest_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(oldestVec));

  // R8: an invalidate not paired with a fill of the same frame removes it
  p_inv_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && !(fillValid && fillPpn == invPpn)) |=> !holdsPpn($past(invPpn)));

  // R10: a filled frame is held afterwards, even against an invalidate
  p_fill_present_r10: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |=> holdsPpn($past(fillPpn)));

endmodule

// File: rtl/cxc_ctrl.sv
module cxc_ctrl
  import cxc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWalk,
  input  logic       fillValid,
  input  logic       lookupHit,
  input  logic       invHitsReq,
  input  logic       fillHitsReq,
  input  logic       fillHitsWait,
  output ctlStrobe_t strobe,
  output logic       reqReady,
  output logic       missPending
);

  phase_t phase, phaseNext;

  always_comb begin
    strobe    = '0;
    phaseNext = phase;
    case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          if (reqWalk) begin
            strobe.loadRsp = 1'b1;
            strobe.rspSrc  = SRC_BYPASS;
          end else if (fillValid && fillHitsReq) begin
            strobe.loadRsp = 1'b1;
            strobe.rspSrc  = SRC_FILL_NOW;
          end else if (lookupHit && !invHitsReq) begin
            strobe.loadRsp  = 1'b1;
            strobe.touchHit = 1'b1;
            strobe.rspSrc   = SRC_ARRAY;
          end else begin
            strobe.latchReq = 1'b1;
            phaseNext       = PH_WAIT;
          end
        end
      end
      PH_WAIT: begin
        if (fillValid && fillHitsWait) begin
          strobe.loadRsp = 1'b1;
          strobe.rspSrc  = SRC_FILL_WAIT;
          phaseNext      = PH_IDLE;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign reqReady    = (phase == PH_IDLE);
  assign missPending = (phase == PH_WAIT);

endmodule

// File: rtl/cmp_xlat_cache.sv
module cmp_xlat_cache
  import cxc_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int FRAME_W = 36,
  parameter int OFF_W   = 12,
  parameter int STATE_W = 2,
  localparam int ADDR_W = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWalk,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic               reqReady,
  output logic               rspValid,
  output logic [ADDR_W-1:0]  rspAddr,
  output logic [STATE_W-1:0] rspState,
  output logic               missPending,
  input  logic               fillValid,
  input  logic [FRAME_W-1:0] fillPpn,
  input  logic [STATE_W-1:0] fillState,
  input  logic [FRAME_W-1:0] fillLoc,
  input  logic               invValid,
  input  logic [FRAME_W-1:0] invPpn
);

  ctlStrobe_t strobe;
  logic lookupHit, invHitsReq, fillHitsReq, fillHitsWait;

  cxc_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqWalk      (reqWalk),
    .fillValid    (fillValid),
    .lookupHit    (lookupHit),
    .invHitsReq   (invHitsReq),
    .fillHitsReq  (fillHitsReq),
    .fillHitsWait (fillHitsWait),
    .strobe       (strobe),
    .reqReady     (reqReady),
    .missPending  (missPending)
  );

  cxc_datapath #(
    .ENTRIES (ENTRIES),
    .FRAME_W (FRAME_W),
    .OFF_W   (OFF_W),
    .STATE_W (STATE_W)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqPpn       (reqAddr[ADDR_W-1:OFF_W]),
    .reqOff       (reqAddr[OFF_W-1:0]),
    .fillValid    (fillValid),
    .fillPpn      (fillPpn),
    .fillState    (fillState),
    .fillLoc      (fillLoc),
    .invValid     (invValid),
    .invPpn       (invPpn),
    .lookupHit    (lookupHit),
    .invHitsReq   (invHitsReq),
    .fillHitsReq  (fillHitsReq),
    .fillHitsWait (fillHitsWait),
    .rspValid     (rspValid),
    .rspAddr      (rspAddr),
    .rspState     (rspState)
  );

  // R2: walker reads come back unchanged one cycle later
  p_walk_bypass_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWalk) |=>
      (rspValid && rspAddr == $past(reqAddr) && rspState == '0));

  // R5: no response while a miss waits
  p_no_rsp_waiting_r5: assert property (@(posedge clk) disable iff (!rstN)
    missPending |-> !rspValid);

  // R5: the matching fill releases the wait with a response
  p_release_on_fill_r5: assert property (@(posedge clk) disable iff (!rstN)
    (missPending && fillValid && fillHitsWait) |=> (rspValid && !missPending));

  // R9: a lookup met by a fill of its frame never misses
  p_fwd_no_miss_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWalk && fillValid &&
     fillPpn == reqAddr[ADDR_W-1:OFF_W]) |=>
      (rspValid && !missPending && rspState == $past(fillState)));

endmodule

// File: tb/test_cmp_xlat_cache.sv
`timescale 1ns/1ps
module test_cmp_xlat_cache;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWalk;
  logic [47:0] reqAddr;
  logic        reqReady, rspValid, missPending;
  logic [47:0] rspAddr;
  logic [1:0]  rspState;
  logic        fillValid;
  logic [35:0] fillPpn, fillLoc;
  logic [1:0]  fillState;
  logic        invValid;
  logic [35:0] invPpn;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cmp_xlat_cache i_cmp_xlat_cache (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWalk(reqWalk), .reqAddr(reqAddr), .reqReady(reqReady),
    .rspValid(rspValid), .rspAddr(rspAddr), .rspState(rspState), .missPending(missPending),
    .fillValid(fillValid), .fillPpn(fillPpn), .fillState(fillState), .fillLoc(fillLoc),
    .invValid(invValid), .invPpn(invPpn)
  );

  // Scoreboard queues
  logic [47:0] expAddr[$];
  logic [1:0]  expSt[$];
  string       expTag[$];

  // Reference LRU list: index 0 is least recently used
  logic [35:0] mPpn[$];
  logic [1:0]  mSt[$];
  logic [35:0] mLoc[$];

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic int mFind(input logic [35:0] p);
    foreach (mPpn[i]) if (mPpn[i] == p) return i;
    return -1;
  endfunction

  task automatic mTouch(input int i);
    logic [35:0] p, l; logic [1:0] s;
    p = mPpn[i]; s = mSt[i]; l = mLoc[i];
    mPpn.delete(i); mSt.delete(i); mLoc.delete(i);
    mPpn.push_back(p); mSt.push_back(s); mLoc.push_back(l);
  endtask

  task automatic mDrop(input logic [35:0] p);
    int i;
    i = mFind(p);
    if (i >= 0) begin mPpn.delete(i); mSt.delete(i); mLoc.delete(i); end
  endtask

  task automatic mFill(input logic [35:0] p, input logic [1:0] s, input logic [35:0] l);
    int i;
    i = mFind(p);
    if (i >= 0) begin mPpn.delete(i); mSt.delete(i); mLoc.delete(i); end
    else if (mPpn.size() == 16) begin void'(mPpn.pop_front()); void'(mSt.pop_front()); void'(mLoc.pop_front()); end
    mPpn.push_back(p); mSt.push_back(s); mLoc.push_back(l);
  endtask

  function automatic logic [47:0] expOf(input logic [35:0] p, input logic [11:0] off,
                                        input logic [1:0] s, input logic [35:0] l);
    return (s == 2'd0) ? {p, off} : {l, off};
  endfunction

  task automatic push(input logic [47:0] a, input logic [1:0] s, input string t);
    expAddr.push_back(a); expSt.push_back(s); expTag.push_back(t);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rstN && rspValid && !finished) begin
      if (expAddr.size() == 0) begin
        chk(1'b0, "R5 unexpected response", 64'(rspAddr), 64'd0);
      end else begin
        logic [47:0] a; logic [1:0] s; string t;
        a = expAddr.pop_front(); s = expSt.pop_front(); t = expTag.pop_front();
        chk(rspAddr === a, {t, " addr"}, 64'(rspAddr), 64'(a));
        chk(rspState === s, {t, " state"}, 64'(rspState), 64'(s));
      end
    end
  end

  task automatic doFill(input logic [35:0] p, input logic [1:0] s, input logic [35:0] l);
    @(negedge clk);
    fillValid = 1'b1; fillPpn = p; fillState = s; fillLoc = l;
    mFill(p, s, l);
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic doInv(input logic [35:0] p);
    @(negedge clk);
    invValid = 1'b1; invPpn = p;
    mDrop(p);
    @(negedge clk);
    invValid = 1'b0;
  endtask

  // Lookup; on a predicted miss the wait is checked and released by a fill (fs, fl)
  task automatic access(input logic [35:0] p, input logic [11:0] off, input bit walk,
                        input string tag, input logic [1:0] fs, input logic [35:0] fl);
    int i;
    i = walk ? -1 : mFind(p);
    @(negedge clk);
    reqValid = 1'b1; reqWalk = walk; reqAddr = {p, off};
    if (walk) push({p, off}, 2'd0, tag);
    else if (i >= 0) begin
      push(expOf(p, off, mSt[i], mLoc[i]), mSt[i], tag);
      mTouch(i);
    end
    @(negedge clk);
    reqValid = 1'b0; reqWalk = 1'b0;
    if (!walk && i < 0) begin
      chk(missPending === 1'b1 && reqReady === 1'b0, {tag, " R5 miss stalls"},
          64'({missPending, reqReady}), 64'b10);
      @(negedge clk);
      chk(missPending === 1'b1, {tag, " R5 stall held"}, 64'(missPending), 64'd1);
      fillValid = 1'b1; fillPpn = p; fillState = fs; fillLoc = fl;
      mFill(p, fs, fl);
      push(expOf(p, off, fs, fl), fs, {tag, " R5 released by fill"});
      @(negedge clk);
      fillValid = 1'b0;
      chk(missPending === 1'b0 && reqReady === 1'b1, {tag, " R5 wait ends"},
          64'({missPending, reqReady}), 64'b01);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam logic [35:0] P0 = 36'h0_1234_5000;
  localparam logic [35:0] P1 = 36'h0_0000_0777;
  localparam logic [35:0] P2 = 36'h0_00AB_CDE0;
  localparam logic [35:0] P3 = 36'h0_00AB_CDE1;
  localparam logic [35:0] P5 = 36'h0_0055_0005;
  localparam logic [35:0] P6 = 36'h0_0066_0006;

  initial begin
    rstN = 1'b0; reqValid = 0; reqWalk = 0; reqAddr = '0;
    fillValid = 0; fillPpn = '0; fillState = '0; fillLoc = '0;
    invValid = 0; invPpn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(reqReady === 1'b1 && missPending === 1'b0 && rspValid === 1'b0, "R1 reset outputs",
        64'({reqReady, missPending, rspValid}), 64'b100);

    // R1/R3: first lookup misses, uncompressed fill gives identity
    access(P0, 12'h0AB, 0, "R1 empty lookup R3 raw", 2'd0, 36'h0);
    access(P0, 12'hFFF, 0, "R3 raw hit", 2'd0, 36'h0);

    // R4: compressed page
    doFill(P1, 2'd2, 36'h9_0000_0042);
    access(P1, 12'h123, 0, "R4 compressed hit", 2'd0, 36'h0);

    // R6: overwrite in place
    doFill(P0, 2'd1, 36'h8_0000_0011);
    access(P0, 12'h010, 0, "R6 overwrite", 2'd0, 36'h0);

    // R2: walker read bypasses a compressed entry
    access(P1, 12'h456, 1, "R2 walk bypass", 2'd0, 36'h0);

    // R5: fill for another frame does not release the wait
    @(negedge clk);
    reqValid = 1'b1; reqWalk = 1'b0; reqAddr = {P2, 12'h321};
    @(negedge clk);
    reqValid = 1'b0;
    chk(missPending === 1'b1, "R5 miss raised", 64'(missPending), 64'd1);
    fillValid = 1'b1; fillPpn = P3; fillState = 2'd3; fillLoc = 36'h7_0000_0003;
    mFill(P3, 2'd3, 36'h7_0000_0003);
    @(negedge clk);
    chk(missPending === 1'b1 && reqReady === 1'b0, "R5 other fill keeps wait",
        64'({missPending, reqReady}), 64'b10);
    fillPpn = P2; fillState = 2'd1; fillLoc = 36'h6_0000_0002;
    mFill(P2, 2'd1, 36'h6_0000_0002);
    push({36'h6_0000_0002, 12'h321}, 2'd1, "R5 matching fill");
    @(negedge clk);
    fillValid = 1'b0;
    chk(missPending === 1'b0, "R5 released", 64'(missPending), 64'd0);
    access(P3, 12'h001, 0, "R5 other fill installed", 2'd0, 36'h0);

    // R9: lookup and fill of the same frame in one cycle
    @(negedge clk);
    reqValid = 1'b1; reqAddr = {P5, 12'h5A5};
    fillValid = 1'b1; fillPpn = P5; fillState = 2'd3; fillLoc = 36'h5_0000_0055;
    mFill(P5, 2'd3, 36'h5_0000_0055);
    push({36'h5_0000_0055, 12'h5A5}, 2'd3, "R9 forwarded fill");
    @(negedge clk);
    reqValid = 1'b0; fillValid = 1'b0;
    chk(missPending === 1'b0 && reqReady === 1'b1, "R9 no miss",
        64'({missPending, reqReady}), 64'b01);

    // R8: invalidate, then lookup misses
    doInv(P1);
    access(P1, 12'h0C0, 0, "R8 lookup after invalidate", 2'd0, 36'h0);

    // R8: lookup and invalidate of the same frame in one cycle
    @(negedge clk);
    reqValid = 1'b1; reqAddr = {P0, 12'h777};
    invValid = 1'b1; invPpn = P0;
    mDrop(P0);
    @(negedge clk);
    reqValid = 1'b0; invValid = 1'b0;
    chk(missPending === 1'b1, "R8 same-cycle invalidate misses", 64'(missPending), 64'd1);
    fillValid = 1'b1; fillPpn = P0; fillState = 2'd0; fillLoc = '0;
    mFill(P0, 2'd0, 36'h0);
    push({P0, 12'h777}, 2'd0, "R8 refill after invalidate");
    @(negedge clk);
    fillValid = 1'b0;

    // R10: fill and invalidate of one frame in one cycle
    doFill(P6, 2'd0, 36'h0);
    @(negedge clk);
    fillValid = 1'b1; fillPpn = P6; fillState = 2'd2; fillLoc = 36'h4_0000_0066;
    invValid = 1'b1; invPpn = P6;
    mFill(P6, 2'd2, 36'h4_0000_0066);
    @(negedge clk);
    fillValid = 1'b0; invValid = 1'b0;
    access(P6, 12'h066, 0, "R10 fill beats invalidate", 2'd0, 36'h0);

    // R7: replacement order
    for (int k = 0; k < 16; k++)
      doFill(36'h200 + 36'(k), 2'(k % 4), 36'h3_0000_0000 + 36'(k));
    access(36'h200, 12'h00A, 0, "R7 touch oldest", 2'd0, 36'h0);
    access(36'h201, 12'h00B, 1, "R7 R2 walk does not touch", 2'd0, 36'h0);
    doFill(36'h300, 2'd1, 36'h2_0000_0300);
    access(36'h201, 12'h00C, 0, "R7 LRU evicted", 2'd0, 36'h0);
    access(36'h200, 12'h00D, 0, "R7 touched survives", 2'd0, 36'h0);
    access(36'h202, 12'h00E, 0, "R7 next LRU evicted", 2'd2, 36'h2_0000_0202);
    doInv(36'h205);
    doFill(36'h301, 2'd0, 36'h0);
    access(36'h203, 12'h00F, 0, "R7 empty entry used first", 2'd0, 36'h0);
    access(36'h301, 12'h010, 0, "R7 fill into empty entry", 2'd0, 36'h0);

    repeat (3) @(negedge clk);
    chk(expAddr.size() == 0, "R5 all responses seen", 64'(expAddr.size()), 64'd0);
    finish_run();
  end

endmodule